// File: doc/BRIEF.md
# Memory Bank Window Configuration and Address Decoder

This block is the configuration side of a DRAM controller that serves six module sockets. Board straps tell it which sockets are populated and which of them carry a large (32 MB) module rather than a small (8 MB) one. Sockets are populated in pairs, and both modules of a pair have the same size. Software sees four byte-wide I/O ports. Three are read-only status ports: large-module identification, socket presence and parity status. The fourth is a size port that holds a table of eight end addresses, each in 8 MB units.

Software lays out memory by writing a chain of end addresses to the size port. Table entry k, for k from 1 to 6, closes the window of socket k-1. That window opens where entry k-1 ends, and the window of socket 0 opens at zero. Reads of the size port walk the table through an internal index that wraps after the last entry. A read of the presence port rewinds that index to the start, so firmware can read the table back in order.

From the table and the straps, the block derives a start unit, an end unit and an enable for each socket. It then decodes a physical memory address into a one-hot bank select and a bank-relative offset, or into an unmapped flag when no window matches.

Top module: `simm_bank_ctrl`

## Requirements
- R1: A read of port 0x803 returns bit n = 1 exactly when socket n is populated and its size strap marks it as 32 MB, for n from 0 to 5. Bits 7:6 read 0.
- R2: A read of port 0x804 returns bit n = 0 when socket n is populated and 1 when it is empty. Bits 7:6 always read 1.
- R3: A read of port 0x820 returns, in bits 4:0, the table entry selected by the read index, with bits 7:5 equal to 0. After each such read the index advances by one, and it wraps from 7 back to 0.
- R4: Any read of port 0x804 sets the read index to 0, so the next size-port read returns entry 0.
- R5: A write to port 0x820 stores bits 4:0 of the data into the table entry numbered by bits 7:5 of the data. The write does not move the read index.
- R6: Socket s, for s from 0 to 5, has an end unit equal to entry s+1 and a start unit equal to entry s, except that socket 0 starts at 0. The socket is enabled only when it is populated and its end unit differs from its start unit.
- R7: A read of port 0x841 always returns 0x01, meaning no parity error.
- R8: For a memory address whose bits 27:23 (the unit) satisfy start ≤ unit < end for an enabled socket, the bank select has exactly one bit set: the bit of the lowest-numbered such socket. The offset is then the address minus start × 2^23.
- R9: When no enabled socket matches, the unmapped flag is 1, the bank select is 0, and the offset equals the address.
- R10: After reset every table entry is 0, the read index is 0, and every address decodes as unmapped.
- R11: A read of any other port address returns 0xFF. A write to any port other than 0x820, including the read-only ports, changes no table entry and does not move the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_present | input | 6 | Socket populated straps, one bit per socket |
| strap_big | input | 6 | Module size straps: 1 = 32 MB, 0 = 8 MB |
| io_addr | input | 12 | I/O port address |
| io_rd | input | 1 | Read strobe; its side effects take place at the clock edge |
| io_wr | input | 1 | Write strobe; the write takes place at the clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr, combinational |
| mem_addr | input | 28 | Physical memory address to decode |
| bank_sel | output | 6 | One-hot bank select |
| bank_offset | output | 28 | Address relative to the start of the selected bank |
| unmapped | output | 1 | No enabled bank covers mem_addr |

## Verification
The bench builds the block with its default parameters: six sockets, eight table entries, a 5-bit unit field and 8 MB units over a 28-bit address. With eight entries, a ninth consecutive size-port read shows the index wrap. With a 5-bit unit, a sweep over all 32 unit values, probing both the first and last byte of each, reaches every bank boundary. Changing the straps during the run, and programming a non-ascending chain, makes the disabled-socket, empty-window and overlapping-window cases reachable.

// File: rtl/simm_pkg.sv
`timescale 1ns/1ps
package simm_pkg;
    localparam int DATA_W = 8;
    parameter logic [15:0] PORT_BIGID = 16'h0803;
    parameter logic [15:0] PORT_PRES  = 16'h0804;
    parameter logic [15:0] PORT_SIZE  = 16'h0820;
    parameter logic [15:0] PORT_PAR   = 16'h0841;
    localparam logic [DATA_W-1:0] PAR_OK   = 8'h01;
    localparam logic [DATA_W-1:0] IDLE_VAL = 8'hFF;
endpackage

// File: rtl/simm_cfg_regs.sv
`timescale 1ns/1ps
module simm_cfg_regs
    import simm_pkg::*;
#(
    parameter int NUM_SOCK = 6,
    parameter int NUM_ENT  = 8,
    parameter int EA_W     = 5,
    parameter int IO_AW    = 12,
    localparam int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SOCK-1:0]            strap_present,
    input  logic [NUM_SOCK-1:0]            strap_big,
    input  logic [IO_AW-1:0]               io_addr,
    input  logic                           io_rd,
    input  logic                           io_wr,
    input  logic [DATA_W-1:0]              io_wdata,
    output logic [DATA_W-1:0]              io_rdata,
    output logic [NUM_ENT-1:0][EA_W-1:0]   ent_o,
    output logic [IDX_W-1:0]               idx_o
);
    typedef struct packed {
        logic [NUM_ENT-1:0][EA_W-1:0] ent;
        logic [IDX_W-1:0]             idx;
    } regs_t;

    regs_t regs_d, regs_q;

    logic hit_big, hit_pres, hit_size, hit_par;
    assign hit_big  = (io_addr == PORT_BIGID[IO_AW-1:0]);
    assign hit_pres = (io_addr == PORT_PRES[IO_AW-1:0]);
    assign hit_size = (io_addr == PORT_SIZE[IO_AW-1:0]);
    assign hit_par  = (io_addr == PORT_PAR[IO_AW-1:0]);

    always_comb begin
        regs_d = regs_q;
        if (io_wr && hit_size) begin
            regs_d.ent[io_wdata[EA_W +: IDX_W]] = io_wdata[EA_W-1:0];
        end
        if (io_rd && hit_pres) begin
            regs_d.idx = '0;
        end else if (io_rd && hit_size) begin
            if (regs_q.idx == IDX_W'(NUM_ENT - 1)) begin
                regs_d.idx = '0;
            end else begin
                regs_d.idx = regs_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        io_rdata = IDLE_VAL;
        if (hit_big) begin
            io_rdata = '0;
            io_rdata[NUM_SOCK-1:0] = strap_present & strap_big;
        end else if (hit_pres) begin
            io_rdata = '1;
            io_rdata[NUM_SOCK-1:0] = ~strap_present;
        end else if (hit_size) begin
            io_rdata = {{(DATA_W-EA_W){1'b0}}, regs_q.ent[regs_q.idx]};
        end else if (hit_par) begin
            io_rdata = PAR_OK;
        end
    end

    assign ent_o = regs_q.ent;
    assign idx_o = regs_q.idx;
endmodule

// File: rtl/simm_bank_map.sv
`timescale 1ns/1ps
module simm_bank_map #(
    parameter int NUM_SOCK = 6,
    parameter int NUM_ENT  = 8,
    parameter int EA_W     = 5
) (
    input  logic [NUM_ENT-1:0][EA_W-1:0]  ent,
    input  logic [NUM_SOCK-1:0]           present,
    output logic [NUM_SOCK-1:0][EA_W-1:0] start_u,
    output logic [NUM_SOCK-1:0][EA_W-1:0] end_u,
    output logic [NUM_SOCK-1:0]           bank_en
);
    for (genvar b = 0; b < NUM_SOCK; b++) begin : g_bank
        if (b == 0) begin : g_first
            assign start_u[b] = '0;
        end else begin : g_chain
            assign start_u[b] = ent[b];
        end
        assign end_u[b]   = ent[b+1];
        assign bank_en[b] = present[b] && (end_u[b] != start_u[b]);
    end
endmodule

// File: rtl/simm_addr_dec.sv
`timescale 1ns/1ps
module simm_addr_dec #(
    parameter int NUM_SOCK   = 6,
    parameter int EA_W       = 5,
    parameter int UNIT_SHIFT = 23,
    localparam int ADDR_W    = UNIT_SHIFT + EA_W
) (
    input  logic [ADDR_W-1:0]             mem_addr,
    input  logic [NUM_SOCK-1:0][EA_W-1:0] start_u,
    input  logic [NUM_SOCK-1:0][EA_W-1:0] end_u,
    input  logic [NUM_SOCK-1:0]           bank_en,
    output logic [NUM_SOCK-1:0]           bank_sel,
    output logic [ADDR_W-1:0]             bank_offset,
    output logic                          unmapped
);
    logic [EA_W-1:0]     unit;
    logic [NUM_SOCK-1:0] hit;
    logic [EA_W-1:0]     base;
    logic                found;

    assign unit = mem_addr[ADDR_W-1 -: EA_W];

    for (genvar b = 0; b < NUM_SOCK; b++) begin : g_cmp
        assign hit[b] = bank_en[b] && (unit >= start_u[b]) && (unit < end_u[b]);
    end

    always_comb begin
        bank_sel = '0;
        base     = '0;
        found    = 1'b0;
        for (int b = 0; b < NUM_SOCK; b++) begin
            if (!found && hit[b]) begin
                bank_sel[b] = 1'b1;
                base        = start_u[b];
                found       = 1'b1;
            end
        end
    end

    assign bank_offset = mem_addr - {base, {UNIT_SHIFT{1'b0}}};
    assign unmapped    = ~|hit;
endmodule

// File: rtl/simm_bank_ctrl.sv
`timescale 1ns/1ps
module simm_bank_ctrl
    import simm_pkg::*;
#(
    parameter int NUM_SOCK   = 6,
    parameter int NUM_ENT    = 8,
    parameter int EA_W       = 5,
    parameter int UNIT_SHIFT = 23,
    parameter int IO_AW      = 12,
    localparam int ADDR_W    = UNIT_SHIFT + EA_W,
    localparam int IDX_W     = $clog2(NUM_ENT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SOCK-1:0] strap_present,
    input  logic [NUM_SOCK-1:0] strap_big,
    input  logic [IO_AW-1:0]    io_addr,
    input  logic                io_rd,
    input  logic                io_wr,
    input  logic [DATA_W-1:0]   io_wdata,
    output logic [DATA_W-1:0]   io_rdata,
    input  logic [ADDR_W-1:0]   mem_addr,
    output logic [NUM_SOCK-1:0] bank_sel,
    output logic [ADDR_W-1:0]   bank_offset,
    output logic                unmapped
);
    logic [NUM_ENT-1:0][EA_W-1:0]  ent;
    logic [IDX_W-1:0]              idx;
    logic [NUM_SOCK-1:0][EA_W-1:0] start_u;
    logic [NUM_SOCK-1:0][EA_W-1:0] end_u;
    logic [NUM_SOCK-1:0]           bank_en;

    simm_cfg_regs #(
        .NUM_SOCK(NUM_SOCK), .NUM_ENT(NUM_ENT), .EA_W(EA_W), .IO_AW(IO_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .strap_present(strap_present), .strap_big(strap_big),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ent_o(ent), .idx_o(idx)
    );

    simm_bank_map #(
        .NUM_SOCK(NUM_SOCK), .NUM_ENT(NUM_ENT), .EA_W(EA_W)
    ) u_map (
        .ent(ent), .present(strap_present),
        .start_u(start_u), .end_u(end_u), .bank_en(bank_en)
    );

    simm_addr_dec #(
        .NUM_SOCK(NUM_SOCK), .EA_W(EA_W), .UNIT_SHIFT(UNIT_SHIFT)
    ) u_dec (
        .mem_addr(mem_addr), .start_u(start_u), .end_u(end_u),
        .bank_en(bank_en), .bank_sel(bank_sel),
        .bank_offset(bank_offset), .unmapped(unmapped)
    );
endmodule

// File: rtl/simm_bank_ctrl_chk.sv
`timescale 1ns/1ps
module simm_bank_ctrl_chk
    import simm_pkg::*;
#(
    parameter int NUM_SOCK = 6,
    parameter int NUM_ENT  = 8,
    parameter int IO_AW    = 12,
    localparam int IDX_W   = $clog2(NUM_ENT)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [IO_AW-1:0]    io_addr,
    input logic                io_rd,
    input logic [DATA_W-1:0]   io_rdata,
    input logic [IDX_W-1:0]    idx,
    input logic [NUM_SOCK-1:0] strap_present,
    input logic [NUM_SOCK-1:0] bank_en,
    input logic [NUM_SOCK-1:0] bank_sel,
    input logic                unmapped
);
    AST_IDX_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == PORT_PRES[IO_AW-1:0]) |=> (idx == '0)); // R4

    AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == PORT_SIZE[IO_AW-1:0]) |=>
        (idx == (($past(idx) == IDX_W'(NUM_ENT - 1)) ? '0 : $past(idx) + IDX_W'(1)))); // R3

    AST_PARITY_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == PORT_PAR[IO_AW-1:0]) |-> (io_rdata == PAR_OK)); // R7

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel)); // R8

    AST_SEL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_sel & ~bank_en) == '0)); // R6

    AST_SEL_POPULATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_sel & ~strap_present) == '0)); // R6

    AST_MISS_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (bank_sel == '0)); // R9
endmodule

bind simm_bank_ctrl simm_bank_ctrl_chk #(
    .NUM_SOCK(NUM_SOCK), .NUM_ENT(NUM_ENT), .IO_AW(IO_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
    .io_rdata(io_rdata), .idx(idx), .strap_present(strap_present),
    .bank_en(bank_en), .bank_sel(bank_sel), .unmapped(unmapped)
);

// File: tb/tb_simm_bank_ctrl.sv
`timescale 1ns/1ps
module tb_simm_bank_ctrl;
    localparam int NS = 6;
    localparam int NE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  strap_present = '1;
    logic [5:0]  strap_big = 6'b000011;
    logic [11:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [27:0] mem_addr = '0;
    logic [5:0]  bank_sel;
    logic [27:0] bank_offset;
    logic        unmapped;

    always #4 clk = ~clk;

    simm_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .strap_present(strap_present),
        .strap_big(strap_big), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .mem_addr(mem_addr), .bank_sel(bank_sel),
        .bank_offset(bank_offset), .unmapped(unmapped)
    );

    typedef struct packed {
        logic        is_dec;
        logic [7:0]  rd;
        logic [5:0]  sel;
        logic        unm;
        logic [27:0] off;
    } item_t;

    item_t exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    int m_ent[NE];
    int m_idx = 0;

    // Monitor: compares queued expectations two ns after the driving edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                item_t it;
                string tg;
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if (!it.is_dec) begin
                    if (io_rdata !== it.rd) begin
                        fails++;
                        $display("FAIL %s: io_rdata=%h expected %h (addr %h)", tg, io_rdata, it.rd, io_addr);
                    end
                end else if (bank_sel !== it.sel || unmapped !== it.unm || bank_offset !== it.off) begin
                    fails++;
                    $display("FAIL %s: addr=%h sel=%b unm=%b off=%h expected sel=%b unm=%b off=%h",
                             tg, mem_addr, bank_sel, unmapped, bank_offset, it.sel, it.unm, it.off);
                end
            end
        end
    end

    task automatic io_write(input logic [11:0] a, input logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_wdata = v; io_wr = 1'b1; io_rd = 1'b0;
        if (a == 12'h820) m_ent[v[7:5]] = int'(v[4:0]);
    endtask

    task automatic io_read(input logic [11:0] a, input string tg);
        item_t it;
        @(negedge clk);
        io_addr = a; io_wr = 1'b0; io_rd = 1'b1;
        it = '0;
        case (a)
            12'h803: it.rd = {2'b00, strap_present & strap_big};
            12'h804: begin it.rd = {2'b11, ~strap_present}; m_idx = 0; end
            12'h820: begin it.rd = 8'(m_ent[m_idx]); m_idx = (m_idx + 1) % NE; end
            12'h841: it.rd = 8'h01;
            default: it.rd = 8'hFF;
        endcase
        exp_q.push_back(it);
        tag_q.push_back(tg);
    endtask

    task automatic dec(input logic [27:0] a, input string tg);
        item_t it;
        int    u;
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0; mem_addr = a;
        it = '0;
        it.is_dec = 1'b1;
        it.unm = 1'b1;
        it.off = a;
        u = int'(a[27:23]);
        for (int b = 0; b < NS; b++) begin
            int st, en;
            st = (b == 0) ? 0 : m_ent[b];
            en = m_ent[b+1];
            if (it.unm && strap_present[b] && en != st && u >= st && u < en) begin
                it.sel[b] = 1'b1;
                it.unm = 1'b0;
                it.off = a - 28'(st << 23);
            end
        end
        exp_q.push_back(it);
        tag_q.push_back(tg);
    endtask

    task automatic sweep(input string tg);
        for (int u = 0; u < 32; u++) begin
            dec(28'(u << 23), tg);
            dec(28'(u << 23) | 28'h7FFFFF, tg);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NE; i++) m_ent[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        dec(28'h0000000, "R10");
        dec(28'h0800000, "R10");
        for (int i = 0; i < NE; i++) io_read(12'h820, "R10");

        // Status ports
        io_read(12'h803, "R1");
        io_read(12'h804, "R2");
        io_read(12'h841, "R7");
        io_read(12'h900, "R11");
        io_read(12'h821, "R11");

        // R5: program an ascending chain
        io_write(12'h820, {3'd0, 5'd0});
        io_write(12'h820, {3'd1, 5'd4});
        io_write(12'h820, {3'd2, 5'd8});
        io_write(12'h820, {3'd3, 5'd9});
        io_write(12'h820, {3'd4, 5'd10});
        io_write(12'h820, {3'd5, 5'd11});
        io_write(12'h820, {3'd6, 5'd12});
        io_write(12'h820, {3'd7, 5'd31});

        // R3 / R4: readback order, rewind and wrap
        io_read(12'h804, "R4");
        for (int i = 0; i < 3; i++) io_read(12'h820, "R3");
        io_read(12'h804, "R4");
        io_read(12'h820, "R4");
        for (int i = 0; i < 9; i++) io_read(12'h820, "R3");

        // R5: write leaves the index alone
        io_read(12'h804, "R4");
        io_read(12'h820, "R5");
        io_write(12'h820, {3'd7, 5'd30});
        io_read(12'h820, "R5");
        io_read(12'h820, "R5");

        // R11: writes to other ports are ignored
        io_write(12'h803, 8'h3F);
        io_write(12'h804, 8'h25);
        io_write(12'h900, 8'h25);
        io_write(12'h841, 8'h5F);
        io_read(12'h841, "R11");
        io_read(12'h804, "R11");
        for (int i = 0; i < NE; i++) io_read(12'h820, "R11");

        // R8 / R6: decode sweep over the ascending chain
        sweep("R8");

        // R6: unpopulated socket 3 is disabled
        @(negedge clk);
        strap_present = 6'b110111;
        io_read(12'h804, "R2");
        io_read(12'h803, "R1");
        sweep("R6");

        // R6 / R8 / R9: empty, inverted and overlapping windows
        @(negedge clk);
        strap_present = '1;
        strap_big = 6'b001111;
        io_read(12'h803, "R1");
        io_write(12'h820, {3'd1, 5'd8});
        io_write(12'h820, {3'd2, 5'd4});
        io_write(12'h820, {3'd3, 5'd6});
        io_write(12'h820, {3'd4, 5'd6});
        io_write(12'h820, {3'd5, 5'd20});
        io_write(12'h820, {3'd6, 5'd31});
        sweep("R8");
        dec(28'hFFFFFFF, "R9");
        dec(28'hF812345, "R9");

        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule